// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block turns an 8-bit page number into two source selections: where a read of that page comes from, and where a write to it goes. It holds no state. The mode flags come from registers outside the block. The memory arrays sit outside it as well. The 256-byte pages form a 64 KiB space, and the block divides it into these regions:

- zero page and stack
- general RAM
- text and graphics display pages
- the I/O switch page
- peripheral slot ROM
- an upper region backed either by ROM or by a bank-switched RAM card

Reads and writes are resolved separately, and overrides are applied on top of the base mapping. Display-page steering takes priority over the auxiliary read and write flags. The alternate low-bank flag moves zero page and stack. It also moves the upper RAM card to its second set of banks. Slot-ROM space has exceptions for slot 3 and for the shared expansion window.

Each output is a 4-bit source code. A memory fabric outside this block decodes it to enable one array or device.

Top module: `bank_mapper`

## Requirements
- R1: Source codes are 0 main RAM, 1 aux RAM, 2 I/O switch space, 3 slot ROM, 4 internal ROM, 5 ROM, 6 card low bank A (main), 7 card low bank B (main), 8 card low bank A (alt), 9 card low bank B (alt), 10 card high RAM (main), 11 card high RAM (alt). Both outputs are pure functions of the current inputs.
- R2: For pages 0x02..0xBF, the read source is aux RAM when `auxRead` is 1 and main RAM otherwise. The write source follows `auxWrite` in the same way. This applies unless R3 or R4 overrides it.
- R3: With `dispSteer` set, pages 0x04..0x07 use aux RAM for both read and write when `dispPage2` is 1, and main RAM when it is 0. `auxRead` and `auxWrite` are ignored for these pages in this case.
- R4: With `dispSteer` and `hiResMode` both set, pages 0x20..0x3F follow `dispPage2` as in R3. With `hiResMode` clear, these pages follow R2.
- R5: Pages 0x00..0x01 read from and write to aux RAM when `altLowBank` is 1, and main RAM otherwise. `auxRead` and `auxWrite` have no effect on them.
- R6: Page 0xC0 maps both read and write to the I/O switch space (2), under every flag setting.
- R7: Writes to pages 0xC1..0xCF go to slot ROM (3). Reads from them come from internal ROM (4) whenever `intSlotRom` is 1.
- R8: With `intSlotRom` clear, reads of 0xC1..0xCF come from slot ROM, with two exceptions that come from internal ROM. Page 0xC3 does so when `slot3Card` is 0. Pages 0xC8..0xCF do so when `expLatch` is 1.
- R9: For pages 0xD0..0xFF, the read source is ROM (5) when `cardRead` is 0. The write source is ROM when `cardWrite` is 0.
- R10: For pages 0xD0..0xDF, with the direction's card enable set, the code is 6 + 2*`altLowBank` + `cardBankB`.
- R11: For pages 0xE0..0xFF, with the direction's card enable set, the code is 10 + `altLowBank`. `cardBankB` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pageNum | input | 8 | Upper address byte (page number) |
| auxRead | input | 1 | Reads of general RAM come from aux RAM |
| auxWrite | input | 1 | Writes of general RAM go to aux RAM |
| dispSteer | input | 1 | Display pages follow dispPage2 for both directions |
| dispPage2 | input | 1 | Selects aux copy of display pages when steering |
| hiResMode | input | 1 | Extends display steering to the graphics pages |
| altLowBank | input | 1 | Alternate zero page/stack and card bank set |
| intSlotRom | input | 1 | Internal ROM covers the whole slot area on reads |
| slot3Card | input | 1 | Slot 3 card ROM visible at page 0xC3 |
| expLatch | input | 1 | Internal ROM owns the expansion window on reads |
| cardRead | input | 1 | Reads of 0xD0..0xFF come from card RAM |
| cardWrite | input | 1 | Writes of 0xD0..0xFF go to card RAM |
| cardBankB | input | 1 | Selects second low card bank |
| readSrc | output | 4 | Read source code (R1 encoding) |
| writeSrc | output | 4 | Write source code (R1 encoding) |

## Verification
Two pairs of functions act on the same page in the same evaluation. In the first, display-page steering and the aux read/write flags both claim pages 0x04..0x07 and 0x20..0x3F. In the second, the alternate low-bank flag moves zero page and also picks the card bank set. The bench sweeps all 256 pages under all 4096 flag combinations, so every pairing of competing flags is applied together. Each result is compared against a model built from the range rules in the requirements. Because read and write are judged separately, a swapped direction (for example, steering that applies only to reads) shows up as a mismatch on the other output.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  localparam int PAGE_W = 8;
  localparam int SRC_W  = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_MAIN     = 4'd0,
    SRC_AUX      = 4'd1,
    SRC_IO       = 4'd2,
    SRC_SLOT     = 4'd3,
    SRC_IROM     = 4'd4,
    SRC_ROM      = 4'd5,
    SRC_LO_BASE  = 4'd6,
    SRC_HI_BASE  = 4'd10
  } srcSel_e;

  // region boundaries (inclusive)
  localparam logic [PAGE_W-1:0] ZP_LAST    = 8'h01;
  localparam logic [PAGE_W-1:0] RAM_LAST   = 8'hBF;
  localparam logic [PAGE_W-1:0] TXT_FIRST  = 8'h04;
  localparam logic [PAGE_W-1:0] TXT_LAST   = 8'h07;
  localparam logic [PAGE_W-1:0] GFX_FIRST  = 8'h20;
  localparam logic [PAGE_W-1:0] GFX_LAST   = 8'h3F;
  localparam logic [PAGE_W-1:0] IO_PAGE    = 8'hC0;
  localparam logic [PAGE_W-1:0] SLOT3_PAGE = 8'hC3;
  localparam logic [PAGE_W-1:0] EXP_FIRST  = 8'hC8;
  localparam logic [PAGE_W-1:0] SLOT_LAST  = 8'hCF;
  localparam logic [PAGE_W-1:0] CLO_LAST   = 8'hDF;

  localparam int DIR_N  = 2;  // 0 = read, 1 = write
  localparam int DIR_RD = 0;
  localparam int DIR_WR = 1;

  typedef struct packed {
    logic              zpRam;     // 0x00..0x01
    logic              genRam;    // 0x02..0xBF
    logic              ioPage;    // 0xC0
    logic              slotPage;  // 0xC1..0xCF
    logic              cardLow;   // 0xD0..0xDF
    logic              cardHigh;  // 0xE0..0xFF
    logic [DIR_N-1:0]  useAux;    // per direction, RAM regions
    logic [DIR_N-1:0]  cardOn;    // per direction, card RAM
    logic              intRomRd;  // internal ROM on read of slot area
    logic [1:0]        lowBank;   // {alt, bankB}
    logic              highAlt;   // high card bank set
  } mapStrobes_t;

endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              auxRead,
  input  logic              auxWrite,
  input  logic              dispSteer,
  input  logic              dispPage2,
  input  logic              hiResMode,
  input  logic              altLowBank,
  input  logic              intSlotRom,
  input  logic              slot3Card,
  input  logic              expLatch,
  input  logic              cardRead,
  input  logic              cardWrite,
  input  logic              cardBankB,
  output mapStrobes_t       strobes
);

  logic inZp, inGen, inIo, inSlot, inLow, inHigh;
  logic inText, inGfx, steerHit;
  logic slotIntHit;
  logic [DIR_N-1:0] dirAuxFlag;
  logic [DIR_N-1:0] dirCardFlag;

  always_comb begin
    inZp   = (pageNum <= ZP_LAST);
    inGen  = (pageNum > ZP_LAST) && (pageNum <= RAM_LAST);
    inIo   = (pageNum == IO_PAGE);
    inSlot = (pageNum > IO_PAGE) && (pageNum <= SLOT_LAST);
    inLow  = (pageNum > SLOT_LAST) && (pageNum <= CLO_LAST);
    inHigh = (pageNum > CLO_LAST);
    inText = (pageNum >= TXT_FIRST) && (pageNum <= TXT_LAST);
    inGfx  = (pageNum >= GFX_FIRST) && (pageNum <= GFX_LAST);
  end

  // display steering overrides aux flags for both directions
  always_comb steerHit = dispSteer && (inText || (inGfx && hiResMode));

  assign dirAuxFlag  = {auxWrite, auxRead};
  assign dirCardFlag = {cardWrite, cardRead};

  // slot area read source: full internal, or slot 3 / expansion exceptions
  always_comb begin
    if (intSlotRom) begin
      slotIntHit = 1'b1;
    end else begin
      slotIntHit = 1'b0;
      if ((pageNum == SLOT3_PAGE) && !slot3Card) slotIntHit = 1'b1;
      if ((pageNum >= EXP_FIRST) && expLatch)    slotIntHit = 1'b1;
    end
  end

  generate
    for (genvar d = 0; d < DIR_N; d++) begin : g_dir
      always_comb begin
        if (inZp)          strobes.useAux[d] = altLowBank;
        else if (steerHit) strobes.useAux[d] = dispPage2;
        else               strobes.useAux[d] = dirAuxFlag[d];
      end
      assign strobes.cardOn[d] = dirCardFlag[d];
    end
  endgenerate

  assign strobes.zpRam    = inZp;
  assign strobes.genRam   = inGen;
  assign strobes.ioPage   = inIo;
  assign strobes.slotPage = inSlot;
  assign strobes.cardLow  = inLow;
  assign strobes.cardHigh = inHigh;
  assign strobes.intRomRd = slotIntHit;
  assign strobes.lowBank  = {altLowBank, cardBankB};
  assign strobes.highAlt  = altLowBank;

endmodule

// File: rtl/bank_mapper_dp.sv
module bank_mapper_dp
  import bank_mapper_pkg::*;
(
  input  mapStrobes_t       strobes,
  output logic [SRC_W-1:0]  readSrc,
  output logic [SRC_W-1:0]  writeSrc
);

  logic [SRC_W-1:0] dirSrc [DIR_N];

  generate
    for (genvar d = 0; d < DIR_N; d++) begin : g_sel
      always_comb begin
        dirSrc[d] = SRC_ROM;
        if (strobes.ioPage) begin
          dirSrc[d] = SRC_IO;
        end else if (strobes.zpRam || strobes.genRam) begin
          dirSrc[d] = strobes.useAux[d] ? SRC_AUX : SRC_MAIN;
        end else if (strobes.slotPage) begin
          if (d == DIR_RD && strobes.intRomRd) dirSrc[d] = SRC_IROM;
          else                                 dirSrc[d] = SRC_SLOT;
        end else if (strobes.cardLow) begin
          if (strobes.cardOn[d])
            dirSrc[d] = SRC_LO_BASE + SRC_W'({strobes.lowBank[1], 1'b0}) + SRC_W'(strobes.lowBank[0]);
          else
            dirSrc[d] = SRC_ROM;
        end else if (strobes.cardHigh) begin
          if (strobes.cardOn[d]) dirSrc[d] = SRC_HI_BASE + SRC_W'(strobes.highAlt);
          else                   dirSrc[d] = SRC_ROM;
        end
      end
    end
  endgenerate

  assign readSrc  = dirSrc[DIR_RD];
  assign writeSrc = dirSrc[DIR_WR];

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
(
  input  logic [7:0] pageNum,
  input  logic       auxRead,
  input  logic       auxWrite,
  input  logic       dispSteer,
  input  logic       dispPage2,
  input  logic       hiResMode,
  input  logic       altLowBank,
  input  logic       intSlotRom,
  input  logic       slot3Card,
  input  logic       expLatch,
  input  logic       cardRead,
  input  logic       cardWrite,
  input  logic       cardBankB,
  output logic [3:0] readSrc,
  output logic [3:0] writeSrc
);

  mapStrobes_t strobes;

  bank_mapper_ctrl u_ctrl (
    .pageNum   (pageNum),
    .auxRead   (auxRead),
    .auxWrite  (auxWrite),
    .dispSteer (dispSteer),
    .dispPage2 (dispPage2),
    .hiResMode (hiResMode),
    .altLowBank(altLowBank),
    .intSlotRom(intSlotRom),
    .slot3Card (slot3Card),
    .expLatch  (expLatch),
    .cardRead  (cardRead),
    .cardWrite (cardWrite),
    .cardBankB (cardBankB),
    .strobes   (strobes)
  );

  bank_mapper_dp u_dp (
    .strobes (strobes),
    .readSrc (readSrc),
    .writeSrc(writeSrc)
  );

endmodule

// File: rtl/bank_mapper_checker.sv
module bank_mapper_checker (
  input logic [7:0] pageNum,
  input logic       altLowBank,
  input logic       dispSteer,
  input logic       cardRead,
  input logic       cardWrite,
  input logic [3:0] readSrc,
  input logic [3:0] writeSrc
);

  always_comb begin
    if (pageNum == 8'hC0) begin
      p_io_both_r6: assert (readSrc == 4'd2 && writeSrc == 4'd2)
        else $error("io page not mapped to switch space");
    end
    if (pageNum <= 8'h01) begin
      p_zp_follow_r5: assert (readSrc == writeSrc && readSrc == {3'b000, altLowBank})
        else $error("zero page source mismatch");
    end
    if (dispSteer && pageNum >= 8'h04 && pageNum <= 8'h07) begin
      p_text_pair_r3: assert (readSrc == writeSrc)
        else $error("steered text page split");
    end
    if (pageNum > 8'hC0 && pageNum <= 8'hCF) begin
      p_slot_write_r7: assert (writeSrc == 4'd3)
        else $error("slot write not to slot space");
    end
    if (pageNum >= 8'hD0 && !cardRead) begin
      p_rom_read_r9: assert (readSrc == 4'd5)
        else $error("card read disabled but not ROM");
    end
    if (pageNum >= 8'hD0 && !cardWrite) begin
      p_rom_write_r9: assert (writeSrc == 4'd5)
        else $error("card write disabled but not ROM");
    end
    if (pageNum >= 8'hE0 && cardRead) begin
      p_high_bank_r11: assert (readSrc == 4'd10 + {3'b000, altLowBank})
        else $error("high card bank mismatch");
    end
    p_code_range_r1: assert (readSrc <= 4'd11 && writeSrc <= 4'd11)
      else $error("source code out of range");
  end

endmodule

bind bank_mapper bank_mapper_checker u_chk (
  .pageNum   (pageNum),
  .altLowBank(altLowBank),
  .dispSteer (dispSteer),
  .cardRead  (cardRead),
  .cardWrite (cardWrite),
  .readSrc   (readSrc),
  .writeSrc  (writeSrc)
);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] pageNum;
  logic auxRead, auxWrite, dispSteer, dispPage2, hiResMode, altLowBank;
  logic intSlotRom, slot3Card, expLatch, cardRead, cardWrite, cardBankB;
  logic [3:0] readSrc, writeSrc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bank_mapper dut (
    .pageNum(pageNum), .auxRead(auxRead), .auxWrite(auxWrite),
    .dispSteer(dispSteer), .dispPage2(dispPage2), .hiResMode(hiResMode),
    .altLowBank(altLowBank), .intSlotRom(intSlotRom), .slot3Card(slot3Card),
    .expLatch(expLatch), .cardRead(cardRead), .cardWrite(cardWrite),
    .cardBankB(cardBankB), .readSrc(readSrc), .writeSrc(writeSrc)
  );

  // reference model, one direction at a time (isWr selects direction)
  function automatic int expSrc(input int pg, input bit isWr, input bit [11:0] f);
    bit aR = f[0], aW = f[1], st = f[2], p2 = f[3], hr = f[4], az = f[5];
    bit ia = f[6], s3 = f[7], ex = f[8], cR = f[9], cW = f[10], bb = f[11];
    bit auxFlag = isWr ? aW : aR;
    bit cardEn  = isWr ? cW : cR;
    if (pg < 2) return az ? 1 : 0;                                   // R5
    if (pg < 'hC0) begin
      if (st && ((pg >= 4 && pg < 8) || (hr && pg >= 'h20 && pg < 'h40)))
        return p2 ? 1 : 0;                                           // R3 R4
      return auxFlag ? 1 : 0;                                        // R2
    end
    if (pg == 'hC0) return 2;                                        // R6
    if (pg < 'hD0) begin
      if (isWr) return 3;                                            // R7
      if (ia) return 4;
      if (pg == 'hC3 && !s3) return 4;                               // R8
      if (pg >= 'hC8 && ex) return 4;
      return 3;
    end
    if (!cardEn) return 5;                                           // R9
    if (pg < 'hE0) return 6 + 2*az + bb;                             // R10
    return 10 + az;                                                  // R11
  endfunction

  function automatic string tagFor(input int pg, input bit isWr, input bit [11:0] f);
    if (pg < 2) return "R5";
    if (pg < 'hC0) begin
      if (f[2] && pg >= 4 && pg < 8) return "R3";
      if (f[2] && pg >= 'h20 && pg < 'h40) return "R4";
      return "R2";
    end
    if (pg == 'hC0) return "R6";
    if (pg < 'hD0) return (isWr || f[6]) ? "R7" : "R8";
    if (!(isWr ? f[10] : f[9])) return "R9";
    if (pg < 'hE0) return "R10";
    return "R11";
  endfunction

  task automatic applyIn(input int pg, input bit [11:0] f);
    pageNum = 8'(pg);
    {cardBankB, cardWrite, cardRead, expLatch, slot3Card, intSlotRom,
     altLowBank, hiResMode, dispPage2, dispSteer, auxWrite, auxRead} = f;
  endtask

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s page=%02h actual=%0d expected=%0d", tag, what, pageNum, act, exp);
    end
  endtask

  task automatic checkBoth(input int pg, input bit [11:0] f);
    applyIn(pg, f);
    #1;
    checkVal(tagFor(pg, 1'b0, f), "read",  int'(readSrc),  expSrc(pg, 1'b0, f));
    checkVal(tagFor(pg, 1'b1, f), "write", int'(writeSrc), expSrc(pg, 1'b1, f));
  endtask

  initial begin
    applyIn(0, 12'h000);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: all-clear flags; codes fixed by the encoding
    checkBoth('h00, 12'h000);
    checkVal("R1", "read",  int'(readSrc), 0);
    checkBoth('hC0, 12'h000);
    checkVal("R1", "io",    int'(readSrc), 2);
    checkBoth('hC3, 12'h000);
    checkVal("R1", "slot3", int'(readSrc), 4);
    checkBoth('hF0, 12'h000);
    checkVal("R1", "rom",   int'(readSrc), 5);

    // R3 override against aux flags: steer+page2 off with aux on
    checkBoth('h05, 12'h007);
    checkVal("R3", "steer main", int'(readSrc), 0);
    // R10 corner: alt set, bank B, card read
    checkBoth('hD4, 12'hA20);
    checkVal("R10", "alt bankB", int'(readSrc), 9);

    // exhaustive sweep: every page under every flag combination
    for (int fl = 0; fl < 4096; fl++) begin
      for (int pg = 0; pg < 256; pg++) begin
        checkBoth(pg, 12'(fl));
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule